// File: doc/BRIEF.md
# Network Controller Interrupt Cause and Mask Unit

This unit gathers interrupt causes for a network controller and combines them into one interrupt line. The datapath reports each cause as a one-cycle pulse on its own bit of an event bus. Software reaches the unit through a 32-bit register port with separate read and write strobes. It reads the pending causes, can raise causes itself, enables and disables each cause individually, and sets a minimum spacing between interrupt assertions.

A read of the cause register returns the pending causes and clears them in the same access. A pulse that arrives in the cycle of that read is kept. A top bit in the cause register shows that the pending enabled causes actually drove the interrupt line. An optional auto-mask feature can disable chosen causes whenever software touches the cause register after an interrupt has fired. A throttle counter, clocked by a 256 ns tick input, delays a new assertion until the programmed interval has passed.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is 0, and the cause, mask, auto-mask and interval registers all read 0.
- R2: Causes exist only at bit positions 0-4, 6, 7, 9, 10 and 12-17. An event pulse on one of these bits sets the same cause bit. Writing 1s to offset 0xC8 ORs them into the cause register, and 0 bits have no effect. Bits 5, 8, 11 and 18-30 always read 0.
- R3: Writing 1s to offset 0xD0 enables those causes, and writing 1s to 0xD8 disables them. Zero bits have no effect. Offset 0xD0 reads back the current enables, and offsets 0xC8 and 0xD8 read 0. The enables change only through these writes or through auto-mask.
- R4: The output rises one cycle after (cause AND enable) becomes nonzero, provided the throttle has expired. It falls one cycle after that value becomes zero.
- R5: Cause bit 31 is set in the same cycle the output rises, and it stays set until a cause read or a cause write with bit 31 at 1.
- R6: A read of offset 0xC0 returns the cause register and clears every bit, including bit 31. An event pulse in the same cycle as the read stays pending.
- R7: Writing 1s to offset 0xC0 clears those cause bits, bit 31 included.
- R8: When `automask_en` is 1 and cause bit 31 is 1, any read or write of 0xC0 disables every cause whose bit is 1 in the auto-mask register (offset 0xE0). In all other cases a cause access leaves the enables unchanged.
- R9: Each rise of the output loads the throttle counter from the interval register. The counter decrements by 1 on each `tick` pulse. The output cannot rise again while the counter is nonzero, so an interval of 0 disables throttling.
- R10: The interval register at 0xC4 holds 16 bits, and its upper bits read 0. The auto-mask register at 0xE0 holds only the cause bit positions listed in R2. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored when wr_en is 1) |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt | input | 18 | Per-cause event pulses from the datapath |
| tick | input | 1 | One-cycle pulse every 256 ns |
| automask_en | input | 1 | Enables the auto-mask feature |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that only one register access happens per cycle, so a cause access never coincides with a write to the enable or auto-mask registers. They also assume that `tick` is the only thing that moves the throttle counter. The bench keeps to these assumptions. It issues every access through tasks that drive exactly one strobe for one cycle, and it holds `tick` low except in the throttle test, where each tick pulse lasts one cycle with no register traffic around it.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int DW      = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_SRC = 18;
    localparam int THR_W   = 16;
    localparam int FLAG_B  = DW - 1;

    // Cause positions that exist; all others read zero.
    localparam logic [NUM_SRC-1:0] SRC_IMPL = 18'h3F6DF;

    localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'hC0;
    localparam logic [ADDR_W-1:0] OFF_THROT = 8'hC4;
    localparam logic [ADDR_W-1:0] OFF_CSET  = 8'hC8;
    localparam logic [ADDR_W-1:0] OFF_MSET  = 8'hD0;
    localparam logic [ADDR_W-1:0] OFF_MCLR  = 8'hD8;
    localparam logic [ADDR_W-1:0] OFF_AMASK = 8'hE0;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CAUSE, SEL_THROT, SEL_CSET, SEL_MSET, SEL_MCLR, SEL_AMASK
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } access_t;

    function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CAUSE: return SEL_CAUSE;
            OFF_THROT: return SEL_THROT;
            OFF_CSET:  return SEL_CSET;
            OFF_MSET:  return SEL_MSET;
            OFF_MCLR:  return SEL_MCLR;
            OFF_AMASK: return SEL_AMASK;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int             N    = 18,
    parameter logic [N-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         rd_clr,
    input  logic [N-1:0] wbits,
    input  logic         wflag,
    input  logic         irq_rise,
    output logic [N-1:0] pend,
    output logic         flag
);
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;

    always_comb begin
        set_v = (evt | (set_we ? wbits : '0)) & IMPL;
        clr_v = rd_clr ? '1 : (clr_we ? wbits : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            flag <= 1'b0;
        end else begin
            pend <= (pend & ~clr_v) | set_v;
            if (rd_clr || (clr_we && wflag))
                flag <= 1'b0;
            else if (irq_rise)
                flag <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int           N    = 18,
    parameter logic [N-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         am_we,
    input  logic         auto_fire,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] mask,
    output logic [N-1:0] amask
);
    logic [N-1:0] on_v;
    logic [N-1:0] off_v;

    always_comb begin
        on_v  = set_we ? (wbits & IMPL) : '0;
        off_v = (clr_we ? wbits : '0) | (auto_fire ? amask : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '0;
            amask <= '0;
        end else begin
            mask <= (mask & ~off_v) | on_v;
            if (am_we)
                amask <= wbits & IMPL;
        end
    end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         int_we,
    input  logic [W-1:0] wval,
    input  logic         tick,
    input  logic         pending,
    output logic [W-1:0] interval,
    output logic [W-1:0] cnt,
    output logic         irq,
    output logic         rise
);
    logic irq_nx;
    logic expired;

    always_comb begin
        expired = (cnt == '0);
        irq_nx  = irq ? pending : (pending && expired);
        rise    = irq_nx && !irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            interval <= '0;
            cnt      <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= irq_nx;
            if (int_we)
                interval <= wval;
            if (rise)
                cnt <= interval;
            else if (tick && !expired)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
    import nic_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NUM_SRC-1:0] evt,
    input  logic              tick,
    input  logic              automask_en,
    output logic              irq
);
    localparam int PAD_C = DW - 1 - NUM_SRC;
    localparam int PAD_M = DW - NUM_SRC;
    localparam int PAD_T = DW - THR_W;

    access_t           acc;
    logic              cause_rd, cause_wr, cause_acc, auto_fire, mask_we;
    logic [NUM_SRC-1:0] pend, mask, amask;
    logic              flag, rise;
    logic [THR_W-1:0]  interval, cnt;
    logic              unused_wbits;

    assign unused_wbits = &{1'b0, wdata[DW-2:NUM_SRC]};

    always_comb begin
        acc.wr  = wr_en;
        acc.rd  = rd_en && !wr_en;
        acc.sel = decode_off(addr);
        cause_rd  = acc.rd && (acc.sel == SEL_CAUSE);
        cause_wr  = acc.wr && (acc.sel == SEL_CAUSE);
        cause_acc = cause_rd || cause_wr;
        auto_fire = cause_acc && automask_en && flag;
        mask_we   = acc.wr && ((acc.sel == SEL_MSET) || (acc.sel == SEL_MCLR));
    end

    irq_cause_bank #(.N(NUM_SRC), .IMPL(SRC_IMPL)) u_cause (
        .clk(clk), .rst(rst), .evt(evt),
        .set_we(acc.wr && (acc.sel == SEL_CSET)),
        .clr_we(cause_wr), .rd_clr(cause_rd),
        .wbits(wdata[NUM_SRC-1:0]), .wflag(wdata[FLAG_B]),
        .irq_rise(rise), .pend(pend), .flag(flag)
    );

    irq_mask_bank #(.N(NUM_SRC), .IMPL(SRC_IMPL)) u_mask (
        .clk(clk), .rst(rst),
        .set_we(acc.wr && (acc.sel == SEL_MSET)),
        .clr_we(acc.wr && (acc.sel == SEL_MCLR)),
        .am_we(acc.wr && (acc.sel == SEL_AMASK)),
        .auto_fire(auto_fire), .wbits(wdata[NUM_SRC-1:0]),
        .mask(mask), .amask(amask)
    );

    irq_throttle #(.W(THR_W)) u_thr (
        .clk(clk), .rst(rst),
        .int_we(acc.wr && (acc.sel == SEL_THROT)),
        .wval(wdata[THR_W-1:0]), .tick(tick),
        .pending(|(pend & mask)),
        .interval(interval), .cnt(cnt), .irq(irq), .rise(rise)
    );

    always_comb begin
        case (acc.sel)
            SEL_CAUSE: rdata = {flag, {PAD_C{1'b0}}, pend};
            SEL_THROT: rdata = {{PAD_T{1'b0}}, interval};
            SEL_MSET:  rdata = {{PAD_M{1'b0}}, mask};
            SEL_AMASK: rdata = {{PAD_M{1'b0}}, amask};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/nic_irq_checker.sv
module nic_irq_checker #(
    parameter int           N    = 18,
    parameter int           W    = 16,
    parameter logic [N-1:0] IMPL = '1
) (
    input logic         clk,
    input logic         rst,
    input logic         irq,
    input logic [N-1:0] pend,
    input logic         flag,
    input logic [N-1:0] mask,
    input logic [N-1:0] amask,
    input logic [W-1:0] cnt,
    input logic [N-1:0] evt,
    input logic         cause_rd,
    input logic         cause_acc,
    input logic         automask_en,
    input logic         mask_we
);
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(pend & mask))); // R4

    AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && !$past(cause_acc)) |-> flag); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cause_rd |=> ((pend == $past(evt & IMPL)) && !flag)); // R6

    AST_AUTOMASK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cause_acc && automask_en && flag) |=> ((mask & $past(amask)) == '0)); // R8

    AST_MASK_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!mask_we && !(cause_acc && automask_en && flag)) |=> $stable(mask)); // R3

    AST_THROTTLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!irq && (cnt != '0)) |=> !irq); // R9
endmodule

bind nic_irq_ctrl nic_irq_checker #(
    .N(nic_irq_pkg::NUM_SRC), .W(nic_irq_pkg::THR_W), .IMPL(nic_irq_pkg::SRC_IMPL)
) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .pend(pend), .flag(flag), .mask(mask),
    .amask(amask), .cnt(cnt), .evt(evt), .cause_rd(cause_rd),
    .cause_acc(cause_acc), .automask_en(automask_en), .mask_we(mask_we)
);

// File: tb/nic_irq_ctrl_bench.sv
module nic_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [17:0] evt = '0;
    logic        tick = 1'b0;
    logic        automask_en = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    nic_irq_ctrl u_nic_irq_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt(evt), .tick(tick),
        .automask_en(automask_en), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{1'b1, 8'hD0, 32'h0000_00FF, 32'h0,        4'd3},  // R3 enable low byte
        '{1'b0, 8'hD0, 32'h0,         32'h0000_00DF, 4'd3},  // R3 bit 5 absent
        '{1'b1, 8'hD8, 32'h0000_000F, 32'h0,        4'd3},
        '{1'b0, 8'hD0, 32'h0,         32'h0000_00D0, 4'd3},
        '{1'b1, 8'hD8, 32'h0,         32'h0,        4'd3},  // R3 zero write
        '{1'b0, 8'hD0, 32'h0,         32'h0000_00D0, 4'd3},
        '{1'b0, 8'hD8, 32'h0,         32'h0,        4'd3},
        '{1'b0, 8'hC8, 32'h0,         32'h0,        4'd3},
        '{1'b1, 8'hC4, 32'hABCD_1234, 32'h0,        4'd10}, // R10
        '{1'b0, 8'hC4, 32'h0,         32'h0000_1234, 4'd10},
        '{1'b1, 8'hE0, 32'hFFFF_FFFF, 32'h0,        4'd10},
        '{1'b0, 8'hE0, 32'h0,         32'h0003_F6DF, 4'd10},
        '{1'b0, 8'h10, 32'h0,         32'h0,        4'd10}, // unmapped
        '{1'b1, 8'hD8, 32'hFFFF_FFFF, 32'h0,        4'd3},
        '{1'b0, 8'hD0, 32'h0,         32'h0,        4'd3},
        '{1'b1, 8'hC8, 32'h0000_0920, 32'h0,        4'd2},  // R2 absent bits
        '{1'b0, 8'hC0, 32'h0,         32'h0,        4'd2},
        '{1'b1, 8'hC8, 32'h0003_0001, 32'h0,        4'd2},
        '{1'b0, 8'hC0, 32'h0,         32'h0003_0001, 4'd6},  // R6 returns
        '{1'b0, 8'hC0, 32'h0,         32'h0,        4'd6},  // R6 cleared
        '{1'b1, 8'hC4, 32'h0,         32'h0,        4'd10},
        '{1'b1, 8'hE0, 32'h0,         32'h0,        4'd10}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [17:0] b);
        @(negedge clk); evt = b;
        @(negedge clk); evt = '0;
    endtask

    task automatic tk();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'hC0, d); chk("R1 cause", d, 32'h0);
        rd(8'hD0, d); chk("R1 mask", d, 32'h0);
        rd(8'hC4, d); chk("R1 interval", d, 32'h0);
        rd(8'hE0, d); chk("R1 automask", d, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) wr(VT[i].addr, VT[i].data);
            else begin
                rd(VT[i].addr, d);
                chk($sformatf("R%0d table %0d", VT[i].req, i), d, VT[i].exp);
            end
        end

        // R2 events on every line, mask off
        pulse(18'h3FFFF);
        chk("R2 masked no irq", {31'b0, irq}, 32'h0);
        rd(8'hC0, d); chk("R2 all events", d, 32'h0003_F6DF);
        pulse(18'h00004);
        rd(8'hC0, d); chk("R2 single event", d, 32'h0000_0004);

        // R4 / R5 assertion timing
        wr(8'hD0, 32'h4);
        pulse(18'h00004);
        chk("R4 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R4 asserted", {31'b0, irq}, 32'h1);
        rd(8'hC0, d); chk("R5 flag set", d, 32'h8000_0004);
        @(negedge clk);
        chk("R4 deasserted", {31'b0, irq}, 32'h0);
        rd(8'hC0, d); chk("R5 flag cleared", d, 32'h0);

        // R7 write-one-to-clear
        wr(8'hD8, 32'hFFFF_FFFF);
        wr(8'hC8, 32'h5);
        wr(8'hC0, 32'h1);
        rd(8'hC0, d); chk("R7 w1c", d, 32'h4);

        // R6 event in the cycle of the read
        pulse(18'h00002);
        @(negedge clk); rd_en = 1'b1; addr = 8'hC0; evt = 18'h00004;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0; evt = '0;
        chk("R6 read value", d, 32'h2);
        rd(8'hC0, d); chk("R6 same-cycle event kept", d, 32'h4);

        // R8 auto-mask fires
        automask_en = 1'b1;
        wr(8'hE0, 32'h1);
        wr(8'hD0, 32'h3);
        pulse(18'h00001);
        @(negedge clk);
        rd(8'hC0, d); chk("R8 cause", d, 32'h8000_0001);
        rd(8'hD0, d); chk("R8 automask applied", d, 32'h2);
        // R8 no flag: no effect
        wr(8'hE0, 32'h3);
        wr(8'hC8, 32'h1);
        rd(8'hC0, d); chk("R8 no flag cause", d, 32'h1);
        rd(8'hD0, d); chk("R8 no flag mask kept", d, 32'h2);
        // R8 disabled: no effect
        automask_en = 1'b0;
        wr(8'hD0, 32'h3);
        pulse(18'h00002);
        @(negedge clk);
        rd(8'hC0, d); chk("R8 off cause", d, 32'h8000_0002);
        rd(8'hD0, d); chk("R8 off mask kept", d, 32'h3);
        wr(8'hE0, 32'h0);

        // R9 throttle
        @(negedge clk);
        wr(8'hD8, 32'hFFFF_FFFF);
        wr(8'hC4, 32'h3);
        wr(8'hD0, 32'h1);
        pulse(18'h00001);
        @(negedge clk);
        chk("R9 first irq", {31'b0, irq}, 32'h1);
        rd(8'hC0, d);
        @(negedge clk);
        chk("R9 dropped", {31'b0, irq}, 32'h0);
        pulse(18'h00001);
        repeat (3) @(negedge clk);
        chk("R9 held back", {31'b0, irq}, 32'h0);
        tk(); tk();
        chk("R9 held after 2 ticks", {31'b0, irq}, 32'h0);
        tk();
        @(negedge clk);
        chk("R9 released", {31'b0, irq}, 32'h1);
        rd(8'hC0, d);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule